// File: doc/BRIEF.md
# Single-Wire Bus Slave Bit Engine

This block is the bit-level front end of a slave on a single open-drain, wire-ANDed bus. It watches the line through a two-stage synchronizer and can pull the line low through `bus_drive_low`. All time is counted in ticks of a `tick` enable. Each tick count starts at a falling edge. Each falling edge opens a slot. If the upper logic has a bit waiting (`tx_valid`), the slot is a read slot: a 0 is returned by holding the line low from the detected edge, and a 1 is returned by leaving the line alone. Otherwise the slot is a write slot: the line is sampled a fixed number of ticks into the slot, and the result is handed up as a one-cycle strobe.

A low pulse that is still low when the minimum reset interval runs out becomes a candidate reset. The reset is only confirmed by the rising edge that ends the pulse. The block then reports it and answers with a presence pulse after a fixed gap. While the upper logic holds `hush` (for example after a failed address match), slots have no effect and only resets are recognised. Command decoding, addressing and memory are left to the logic above. The upper logic sends and receives bytes least-significant bit first, one slot per bit.

Top module: `owslv_phy`

## Requirements
- R1: After reset, `bus_drive_low`, `rx_valid`, `tx_req` and `reset_seen` are 0.
- R2: In a write slot (`tx_valid` 0 at the edge), `rx_valid` pulses for exactly one clock T_SAMPLE (25) ticks after the detected falling edge, and `rx_data` carries the synchronized line level at that moment (1 = high). With one tick per clock, the pulse is seen 27 clocks after the clock edge that first samples the low `bus_in`.
- R3: In a read slot with `tx_bit` 0, `bus_drive_low` rises at the detected falling edge (2 clocks after `bus_in` is first sampled low) and falls T_ZERO_HOLD (30) ticks later.
- R4: At the detected falling edge of every read slot, `tx_req` pulses for one clock to mark the bit as consumed. A `tx_bit` of 1 never drives the line. A read slot never raises `rx_valid`.
- R5: If the line is still low T_RST_MIN (400) ticks after a falling edge, `reset_seen` pulses once, 2 clocks after the rising edge that ends the low pulse.
- R6: A low pulse that ends before T_RST_MIN ticks is an ordinary slot and gives no `reset_seen`.
- R7: A low pulse far beyond the nominal maximum reset time (660 ticks) is still accepted as a reset.
- R8: T_PRES_WAIT (30) ticks after `reset_seen`, `bus_drive_low` is held high for T_PRES_LEN (160) ticks as the presence pulse.
- R9: While `hush` is 1 at the falling edge, the slot gives no `rx_valid`, no `tx_req` and no drive, but a reset is still recognised.
- R10: All delays are counted in `tick` enables, not clocks. With one tick every third clock, the write-slot sample moves to about 77 clocks after the edge.
- R11: A falling edge inside a running slot restarts the slot timing, so back-to-back slots each deliver their own bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Time-base enable; one tick is one timing unit |
| bus_in | input | 1 | Raw bus line level (1 = released/high) |
| bus_drive_low | output | 1 | 1 pulls the bus low |
| hush | input | 1 | 1 makes slots inert; only resets are recognised |
| tx_valid | input | 1 | A bit is waiting to be sent in the next slot |
| tx_bit | input | 1 | Bit value to send |
| tx_req | output | 1 | One-clock pulse: the waiting bit was taken by a slot |
| rx_valid | output | 1 | One-clock pulse: a written bit was sampled |
| rx_data | output | 1 | Sampled bit value, valid with `rx_valid` |
| reset_seen | output | 1 | One-clock pulse when a bus reset ends |

## Verification
The bench attacks the reset boundary from both sides. A 350-tick pulse must not count as a reset. A 480-tick pulse and an 800-tick pulse must, so a design that compared against the maximum, or that reported at the timeout instead of at the rising edge, shows a missing or early `reset_seen`. Eight slots run back to back to form a byte least-significant bit first. A design that did not restart its timer on a new edge in mid-slot would lose or shift bits. The bench also runs slots under `hush`, which would show up as a spurious strobe or drive, and slows the tick to one in three clocks, which exposes any delay counted in clocks instead of ticks.

// File: rtl/owslv_pkg.sv
package owslv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SLOT,
    ST_WAIT_RISE,
    ST_PRES_WAIT,
    ST_PRES_DRIVE
  } owslv_state_t;

  // True on the tick that brings a count started at zero up to lim ticks
  function automatic logic reached(input logic tk, input int unsigned cnt,
                                   input int unsigned lim);
    return tk && (cnt + 1 == lim);
  endfunction

endpackage

// File: rtl/owslv_sync.sv
module owslv_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout,
  output logic fall,
  output logic rise
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= din;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign dout = s2;
  assign fall = s3 & ~s2;
  assign rise = ~s3 & s2;

endmodule

// File: rtl/owslv_timer.sv
module owslv_timer #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        count <= '0;
    else if (clr)                      count <= '0;
    else if (tick && (count != '1))    count <= count + 1'b1;
  end
endmodule

// File: rtl/owslv_phy.sv
module owslv_phy
  import owslv_pkg::*;
#(
  parameter int unsigned T_RST_MIN   = 400,
  parameter int unsigned T_PRES_WAIT = 30,
  parameter int unsigned T_PRES_LEN  = 160,
  parameter int unsigned T_SAMPLE    = 25,
  parameter int unsigned T_ZERO_HOLD = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic bus_in,
  output logic bus_drive_low,
  input  logic hush,
  input  logic tx_valid,
  input  logic tx_bit,
  output logic tx_req,
  output logic rx_valid,
  output logic rx_data,
  output logic reset_seen
);
  localparam int CNT_W = $clog2(T_RST_MIN + T_PRES_LEN + 2);

  owslv_state_t state;
  logic line_s, fall_s, rise_s;
  logic [CNT_W-1:0] cnt;
  logic slot_read, slot_hush;

  // Named internal events
  logic slot_start, ev_sample, ev_zero, ev_rst, ev_pw, ev_pl, tmr_clr;

  owslv_sync u_sync (
    .clk(clk), .rst_n(rst_n), .din(bus_in),
    .dout(line_s), .fall(fall_s), .rise(rise_s)
  );

  owslv_timer #(.W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .tick(tick), .count(cnt)
  );

  always_comb begin
    slot_start = fall_s && ((state == ST_IDLE) || (state == ST_SLOT));
    ev_sample  = reached(tick, 32'(cnt), T_SAMPLE);
    ev_zero    = reached(tick, 32'(cnt), T_ZERO_HOLD);
    ev_rst     = reached(tick, 32'(cnt), T_RST_MIN);
    ev_pw      = reached(tick, 32'(cnt), T_PRES_WAIT);
    ev_pl      = reached(tick, 32'(cnt), T_PRES_LEN);
    tmr_clr    = slot_start
              || ((state == ST_WAIT_RISE) && rise_s)
              || ((state == ST_PRES_WAIT) && ev_pw);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      bus_drive_low <= 1'b0;
      slot_read     <= 1'b0;
      slot_hush     <= 1'b0;
      tx_req        <= 1'b0;
      rx_valid      <= 1'b0;
      rx_data       <= 1'b0;
      reset_seen    <= 1'b0;
    end else begin
      tx_req     <= 1'b0;
      rx_valid   <= 1'b0;
      reset_seen <= 1'b0;
      unique case (state)
        ST_IDLE, ST_SLOT: begin
          if (slot_start) begin
            state         <= ST_SLOT;
            slot_read     <= tx_valid && !hush;
            slot_hush     <= hush;
            tx_req        <= tx_valid && !hush;
            bus_drive_low <= tx_valid && !hush && !tx_bit;
          end else if (state == ST_SLOT) begin
            if (ev_zero) bus_drive_low <= 1'b0;
            if (ev_sample && !slot_read && !slot_hush) begin
              rx_valid <= 1'b1;
              rx_data  <= line_s;
            end
            if (ev_rst) state <= line_s ? ST_IDLE : ST_WAIT_RISE;
          end
        end
        ST_WAIT_RISE: begin
          if (rise_s) begin
            reset_seen <= 1'b1;
            state      <= ST_PRES_WAIT;
          end
        end
        ST_PRES_WAIT: begin
          if (ev_pw) begin
            bus_drive_low <= 1'b1;
            state         <= ST_PRES_DRIVE;
          end
        end
        ST_PRES_DRIVE: begin
          if (ev_pl) begin
            bus_drive_low <= 1'b0;
            state         <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Drive only comes from a read slot or the presence pulse
  AST_DRIVE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive_low |-> ((state == ST_SLOT) && slot_read) || (state == ST_PRES_DRIVE)); // R3

  AST_PRES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PRES_DRIVE) |-> bus_drive_low); // R8

  AST_RX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R2

  AST_RX_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (!slot_read && !slot_hush)); // R4

  AST_RESET_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    reset_seen |-> ((state == ST_PRES_WAIT) && ($past(state) == ST_WAIT_RISE))); // R5

  AST_HUSH_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> !slot_hush); // R9

endmodule

// File: tb/test_owslv_phy.sv
module test_owslv_phy;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic m_low = 1'b0;
  logic hush = 1'b0;
  logic tx_valid = 1'b0;
  logic tx_bit = 1'b1;
  logic bus_drive_low, tx_req, rx_valid, rx_data, reset_seen;
  wire  bus_in = !(m_low || bus_drive_low);

  int checks = 0, errors = 0;
  int cyc = 0, tdiv = 1, tph = 0;
  int drv_n = 0, drv_on = -1, drv_off = -1;
  int rx_n = 0, rx_cyc = -1, rx_d = -1;
  int rs_n = 0, rs_cyc = -1;
  int tq_n = 0, tq_cyc = -1;
  logic pd = 1'b0;

  owslv_phy i_owslv_phy (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_in(bus_in),
    .bus_drive_low(bus_drive_low), .hush(hush), .tx_valid(tx_valid),
    .tx_bit(tx_bit), .tx_req(tx_req), .rx_valid(rx_valid),
    .rx_data(rx_data), .reset_seen(reset_seen)
  );

  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    tick = (tph == 0);
    tph  = (tph + 1 >= tdiv) ? 0 : tph + 1;
  end

  // Event recorder (after output update)
  always @(posedge clk) begin
    #1;
    if (bus_drive_low && !pd) begin drv_n++; drv_on = cyc; end
    if (!bus_drive_low && pd) drv_off = cyc;
    pd = bus_drive_low;
    if (rx_valid)   begin rx_n++; rx_cyc = cyc; rx_d = rx_data; end
    if (reset_seen) begin rs_n++; rs_cyc = cyc; end
    if (tx_req)     begin tq_n++; tq_cyc = cyc; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic low_pulse(input int len, output int t0);
    @(negedge clk);
    m_low = 1'b1;
    t0 = cyc + 1;
    repeat (len) @(negedge clk);
    m_low = 1'b0;
  endtask

  initial begin
    repeat (50000 * 3) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int t0, n0, q0, r0, b;
    logic [7:0] byte_v;
    repeat (5) @(negedge clk);
    chk(!bus_drive_low && !rx_valid && !tx_req && !reset_seen, "R1 reset outputs",
        {bus_drive_low, rx_valid, tx_req, reset_seen}, 0);
    rst_n = 1'b1;
    idle(5);

    // R2 write-1 slot
    n0 = rx_n;
    low_pulse(6, t0); idle(80);
    chk(rx_n == n0 + 1, "R2 write1 strobe count", rx_n - n0, 1);
    chk(rx_cyc == t0 + 27, "R2 write1 sample time", rx_cyc, t0 + 27);
    chk(rx_d == 1, "R2 write1 data", rx_d, 1);
    chk(drv_n == 0, "R2 no drive in write slot", drv_n, 0);

    // R2 write-0 slot
    low_pulse(60, t0); idle(40);
    chk(rx_cyc == t0 + 27, "R2 write0 sample time", rx_cyc, t0 + 27);
    chk(rx_d == 0, "R2 write0 data", rx_d, 0);
    idle(450);

    // R3 read slot, bit 0
    tx_valid = 1'b1; tx_bit = 1'b0; n0 = rx_n; q0 = tq_n;
    low_pulse(6, t0); idle(60);
    chk(drv_on == t0 + 2, "R3 drive start", drv_on, t0 + 2);
    chk(drv_off == t0 + 32, "R3 drive release", drv_off, t0 + 32);
    chk(tq_n == q0 + 1 && tq_cyc == t0 + 2, "R4 req at read0", tq_cyc, t0 + 2);
    chk(rx_n == n0, "R4 no strobe in read0", rx_n - n0, 0);

    // R4 read slot, bit 1
    tx_bit = 1'b1; r0 = drv_n;
    low_pulse(6, t0); idle(60);
    chk(drv_n == r0, "R4 read1 no drive", drv_n - r0, 0);
    chk(tq_cyc == t0 + 2, "R4 req at read1", tq_cyc, t0 + 2);
    chk(rx_n == n0, "R4 no strobe in read1", rx_n - n0, 0);
    tx_valid = 1'b0;
    idle(450);

    // R11 back-to-back write slots: 0xA5 LSB first
    byte_v = 8'h00;
    for (int i = 0; i < 8; i++) begin
      b = (8'hA5 >> i) & 1;
      low_pulse(b ? 6 : 60, t0);
      idle(70 - (b ? 6 : 60));
      chk(rx_cyc == t0 + 27, "R11 restarted slot timing", rx_cyc, t0 + 27);
      byte_v[i] = rx_d[0];
    end
    chk(byte_v == 8'hA5, "R11 byte LSB first", byte_v, 8'hA5);
    idle(450);

    // R6 short pulse
    r0 = rs_n;
    low_pulse(350, t0); idle(600);
    chk(rs_n == r0, "R6 short pulse no reset", rs_n - r0, 0);

    // R5 / R8 reset and presence
    low_pulse(480, t0); idle(300);
    chk(rs_n == r0 + 1, "R5 one reset", rs_n - r0, 1);
    chk(rs_cyc == t0 + 482, "R5 reset on rising edge", rs_cyc, t0 + 482);
    chk(drv_on == t0 + 512, "R8 presence start", drv_on, t0 + 512);
    chk(drv_off == t0 + 672, "R8 presence end", drv_off, t0 + 672);

    // R7 overlong reset
    low_pulse(800, t0); idle(300);
    chk(rs_cyc == t0 + 802, "R7 long reset accepted", rs_cyc, t0 + 802);

    // R9 hush
    hush = 1'b1; tx_valid = 1'b1; tx_bit = 1'b0;
    n0 = rx_n; q0 = tq_n; r0 = drv_n;
    low_pulse(6, t0); idle(60);
    tx_valid = 1'b0;
    low_pulse(60, t0); idle(450);
    chk(rx_n == n0, "R9 hush no strobe", rx_n - n0, 0);
    chk(tq_n == q0, "R9 hush no req", tq_n - q0, 0);
    chk(drv_n == r0, "R9 hush no drive", drv_n - r0, 0);
    low_pulse(480, t0); idle(300);
    chk(rs_cyc == t0 + 482, "R9 reset under hush", rs_cyc, t0 + 482);
    hush = 1'b0;

    // R10 slow tick
    tdiv = 3; idle(10);
    n0 = rx_n;
    low_pulse(120, t0); idle(1400);
    chk(rx_n == n0 + 1, "R10 strobe count", rx_n - n0, 1);
    chk(rx_cyc >= t0 + 74 && rx_cyc <= t0 + 80, "R10 tick-scaled sample", rx_cyc, t0 + 77);
    chk(rx_d == 0, "R10 data", rx_d, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule